// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Handling

This block receives characters from an asynchronous serial line. A 16x oversampling tick enable paces it. A falling edge on the synchronized line starts a candidate start bit, which must stay low for half a bit before it is accepted. Data bits, an optional parity bit and the stop bit are then sampled at their bit centres, least significant bit first. Each completed character goes into a three-entry receive FIFO together with its status flags: parity error, framing error, break and overrun. The ready flag is high whenever the FIFO holds at least one character.

Two line conditions get special handling. The first is a framing error on a character that is not a break: if the line is still low half a bit after the stop sample, that low level is taken as the next start bit. The second is a break, where the whole frame reads low. The block stores one zero character marked as a break, then waits for half a bit of continuous idle before it looks for a new start. A break that begins partway through a character therefore produces two entries: the damaged character flagged with a framing error, followed by a separate break character.

Top module: `serial_rx_break`

## Requirements
- R1: A start search begins only on a high-to-low transition of the synchronized line. If the line reads high on any of the 8 ticks that follow, the candidate is rejected, nothing is stored and the search resumes.
- R2: After the start bit is accepted, every data bit is sampled once at its bit centre, 16 ticks apart. The first data bit received lands in bit 0 of the stored byte.
- R3: The character length is chosen by `char_len_i`, where 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Stored bits above the selected length are zero.
- R4: Parity is selected by `par_mode_i`: 0 = none, 1 = even, 2 = odd, 3 = none. When parity is enabled, the bit after the last data bit is the parity bit. The parity error flag is set when the data bits and the parity bit together have the wrong count of ones. With parity disabled, the flag is always 0.
- R5: A character is written when its stop bit is sampled at the stop-bit centre. `ready_o` rises one to two clocks later and stays high while the FIFO is not empty.
- R6: A character that is not a break and whose stop bit samples low is stored with the framing error flag set.
- R7: After such a framing error, the line is sampled again 8 ticks after the stop sample. If it is low, that level is accepted as a new start bit without an edge search. If it is high, the receiver returns to the edge search and stores nothing more.
- R8: A frame whose start, data, parity and stop samples all read low is stored as data 0x00 with only the break flag set (parity and framing flags 0). No new start search begins until the line has been high for 8 consecutive ticks.
- R9: A break that starts partway through a nonzero character yields two entries in order: the damaged character with its framing error, then a 0x00 break character.
- R10: The FIFO holds 3 entries. A character that completes while the FIFO is full and no pop is made is dropped, and the overrun flag of the newest stored entry is set.
- R11: A one-cycle pulse on `pop_i` removes the head entry. A pop on an empty FIFO has no effect.
- R12: After reset the FIFO is empty, `ready_o` is low, the line is treated as idle-high and the receiver is searching for a start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | Oversampling enable, 16 per bit time |
| char_len_i | input | 2 | Data bits per character minus 5 |
| par_mode_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| pop_i | input | 1 | Remove the head FIFO entry |
| ready_o | output | 1 | FIFO holds at least one character |
| data_o | output | 8 | Data of the head entry |
| perr_o | output | 1 | Parity error of the head entry |
| ferr_o | output | 1 | Framing error of the head entry |
| brk_o | output | 1 | Break flag of the head entry |
| ovr_o | output | 1 | Overrun flag of the head entry |

## Verification
The bench uses the default parameters: 16 ticks per bit, 8-bit data, a three-entry FIFO and a two-stage synchronizer. It fires the tick on every fourth clock, so one bit time is 64 clocks. A break of two dozen bit times therefore spans both the framing-error restart and the idle-guard window, and only four back-to-back characters are needed to reach overrun. Because the FIFO is only three deep, the full, overrun and pop-when-empty cases all come within reach of short scenarios. The bench predicts each entry's data and flags from the bits it drives and checks them as it drains the FIFO.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_FECHK, ST_BRKW
  } rx_state_e;

  typedef struct packed {
    logic perr;
    logic ferr;
    logic brk;
  } rx_stat_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  // reset to idle-high so no false edge appears out of reset
  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx,
  input  logic              tick,
  input  logic [1:0]        len_i,
  input  logic [1:0]        pmode_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output rx_stat_t          stat_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] CNT_HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(OVS - 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] sh;
  logic              perr_q, all_low, rx_q;
  logic [BW-1:0]     last_idx;
  logic              par_en, par_odd, at_half, at_full;

  assign last_idx = BW'(DATA_W - 4) + BW'(len_i);
  assign par_en   = (pmode_i == 2'd1) || (pmode_i == 2'd2);
  assign par_odd  = (pmode_i == 2'd2);
  assign at_half  = tick && (cnt == CNT_HALF);
  assign at_full  = tick && (cnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sh      <= '0;
      perr_q  <= 1'b0;
      all_low <= 1'b0;
      rx_q    <= 1'b1;
      push_o  <= 1'b0;
      data_o  <= '0;
      stat_o  <= '0;
    end else begin
      rx_q   <= rx;
      push_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (rx_q && !rx) st <= ST_START;
        end
        ST_START: begin
          if (tick) begin
            if (rx) begin
              st <= ST_IDLE;
            end else if (at_half) begin
              st      <= ST_DATA;
              cnt     <= '0;
              bidx    <= '0;
              sh      <= '0;
              perr_q  <= 1'b0;
              all_low <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (at_full) begin
            cnt      <= '0;
            sh[bidx] <= rx;
            all_low  <= all_low & ~rx;
            if (bidx == last_idx) st <= par_en ? ST_PAR : ST_STOP;
            else                  bidx <= bidx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_full) begin
            cnt     <= '0;
            perr_q  <= (^sh) ^ rx ^ par_odd;
            all_low <= all_low & ~rx;
            st      <= ST_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_full) begin
            cnt    <= '0;
            push_o <= 1'b1;
            data_o <= sh;
            if (rx) begin
              stat_o <= '{perr: perr_q, ferr: 1'b0, brk: 1'b0};
              st     <= ST_IDLE;
            end else if (all_low) begin
              stat_o <= '{perr: 1'b0, ferr: 1'b0, brk: 1'b1};
              st     <= ST_BRKW;
            end else begin
              stat_o <= '{perr: perr_q, ferr: 1'b1, brk: 1'b0};
              st     <= ST_FECHK;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FECHK: begin
          if (at_half) begin
            cnt <= '0;
            if (!rx) begin
              st      <= ST_DATA;
              bidx    <= '0;
              sh      <= '0;
              perr_q  <= 1'b0;
              all_low <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BRKW: begin
          if (tick) begin
            if (!rx)          cnt <= '0;
            else if (at_half) begin
              cnt <= '0;
              st  <= ST_IDLE;
            end else          cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1
  start_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && tick && rx) |=> (st == ST_IDLE && !push_o));

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    push_o |-> ((data_o >> (DATA_W - 3 + int'($past(len_i)))) == '0));

  // R8
  brk_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (push_o && stat_o.brk) |-> (data_o == '0 && !stat_o.ferr && !stat_o.perr));

  // R8
  brk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BRKW && !rx) |=> (st == ST_BRKW));
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  rx_stat_t          sin,
  input  logic              pop,
  output logic              ready,
  output logic [DATA_W-1:0] dout,
  output rx_stat_t          sout,
  output logic              ovr
);
  localparam int PW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0]   PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

  logic [DATA_W-1:0] dmem [DEPTH];
  rx_stat_t          smem [DEPTH];
  logic [DEPTH-1:0]  ovr_r;
  logic [PW-1:0]     rd, wr, newest;
  logic [CNTW-1:0]   count;
  logic              full, do_pop, do_push, mark_ovr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_FULL);
  assign do_pop   = pop && (count != '0);
  assign do_push  = push && (!full || do_pop);
  assign mark_ovr = push && full && !do_pop;
  assign newest   = (wr == '0) ? PTR_LAST : wr - 1'b1;

  // storage without reset so it can map to a RAM
  always_ff @(posedge clk) begin
    if (do_push) begin
      dmem[wr] <= din;
      smem[wr] <= sin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd    <= '0;
      wr    <= '0;
      count <= '0;
      ovr_r <= '0;
    end else begin
      if (do_push) begin
        wr        <= nxt(wr);
        ovr_r[wr] <= 1'b0;
      end
      if (mark_ovr) ovr_r[newest] <= 1'b1;
      if (do_pop)   rd <= nxt(rd);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign ready = (count != '0);
  assign dout  = dmem[rd];
  assign sout  = smem[rd];
  assign ovr   = ovr_r[rd];

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (count <= CNT_FULL));

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == CNT_FULL && $stable(wr)));

  // R11
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0 && !push) |=> (count == '0 && $stable(rd)));
endmodule

// File: rtl/serial_rx_break.sv
module serial_rx_break
  import srx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic [1:0]        char_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              pop_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o,
  output logic              ovr_o
);
  logic              rx_s, push;
  logic [DATA_W-1:0] wdata;
  rx_stat_t          wstat, hstat;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_i), .dout(rx_s)
  );

  srx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .rx(rx_s), .tick(tick_i),
    .len_i(char_len_i), .pmode_i(par_mode_i),
    .push_o(push), .data_o(wdata), .stat_o(wstat)
  );

  srx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(wdata), .sin(wstat),
    .pop(pop_i), .ready(ready_o), .dout(data_o), .sout(hstat), .ovr(ovr_o)
  );

  assign perr_o = hstat.perr;
  assign ferr_o = hstat.ferr;
  assign brk_o  = hstat.brk;
endmodule

// File: tb/serial_rx_break_bench.sv
module serial_rx_break_bench;
  localparam int BT = 64;  // clocks per bit: 16 ticks, one tick per 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_i = 1'b1;
  logic       tick_i = 1'b0;
  logic [1:0] char_len_i = 2'd3;
  logic [1:0] par_mode_i = 2'd0;
  logic       pop_i = 1'b0;
  logic       ready_o, perr_o, ferr_o, brk_o, ovr_o;
  logic [7:0] data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int tcnt = 0;

  typedef struct {
    logic [7:0] d;
    bit pe, fe, bk, ov;
  } ent_t;
  ent_t q[$];

  serial_rx_break u_serial_rx_break (
    .clk(clk), .rst(rst), .rx_i(rx_i), .tick_i(tick_i),
    .char_len_i(char_len_i), .par_mode_i(par_mode_i), .pop_i(pop_i),
    .ready_o(ready_o), .data_o(data_o), .perr_o(perr_o), .ferr_o(ferr_o),
    .brk_o(brk_o), .ovr_o(ovr_o)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tcnt   <= (tcnt == 3) ? 0 : tcnt + 1;
    tick_i <= (tcnt == 3);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_i = v;
    repeat (n) @(negedge clk);
  endtask

  // reference model: a completed character lands in the queue, or marks overrun
  function automatic void expect_char(input logic [7:0] d, input bit pe, fe, bk);
    ent_t e;
    if (q.size() == 3) begin
      q[2].ov = 1'b1;
    end else begin
      e.d = d; e.pe = pe; e.fe = fe; e.bk = bk; e.ov = 1'b0;
      q.push_back(e);
    end
  endfunction

  task automatic frame(input logic [7:0] d, input int len, input int pm,
                       input bit flip, input int stop_low);
    logic [7:0] m;
    logic p;
    char_len_i = 2'(len - 5);
    par_mode_i = 2'(pm);
    m = d & 8'((1 << len) - 1);
    hold(1'b0, BT);
    for (int i = 0; i < len; i++) hold(d[i], BT);
    if (pm == 1 || pm == 2) begin
      p = (pm == 1) ? ^m : ~^m;
      hold(p ^ flip, BT);
    end
    if (stop_low > 0) hold(1'b0, stop_low);
    hold(1'b1, 2 * BT);
    expect_char(m, (pm == 1 || pm == 2) && flip, stop_low > 0, 1'b0);
  endtask

  task automatic drain(input string tag);
    ent_t e;
    while (q.size() > 0) begin
      e = q.pop_front();
      chk(ready_o === 1'b1, {tag, " ready"}, ready_o, 1);
      chk(data_o === e.d, {tag, " data"}, data_o, e.d);
      chk(perr_o === e.pe, {tag, " perr"}, perr_o, e.pe);
      chk(ferr_o === e.fe, {tag, " ferr"}, ferr_o, e.fe);
      chk(brk_o === e.bk, {tag, " brk"}, brk_o, e.bk);
      chk(ovr_o === e.ov, {tag, " ovr"}, ovr_o, e.ov);
      pop_i = 1'b1;
      @(negedge clk);
      pop_i = 1'b0;
      @(negedge clk);
    end
    chk(ready_o === 1'b0, {tag, " empty after drain"}, ready_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ready_o === 1'b0, "R12 ready in reset", ready_o, 0);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    chk(ready_o === 1'b0, "R12 ready after reset", ready_o, 0);

    // R2 LSB first, R5 ready timing around the stop-bit centre
    char_len_i = 2'd3; par_mode_i = 2'd0;
    hold(1'b0, BT);
    for (int i = 0; i < 8; i++) hold(8'hC4 >> i, BT);
    hold(1'b1, 20);
    chk(ready_o === 1'b0, "R5 ready before stop centre", ready_o, 0);
    hold(1'b1, 36);
    chk(ready_o === 1'b1, "R5 ready after stop centre", ready_o, 1);
    hold(1'b1, BT);
    expect_char(8'hC4, 0, 0, 0);
    drain("R2 lsb-first");

    // R1 short low glitch is not a start
    hold(1'b0, 20);
    hold(1'b1, 3 * BT);
    chk(ready_o === 1'b0, "R1 glitch rejected", ready_o, 0);

    // R3 and R4 lengths and parity
    frame(8'hF3, 5, 1, 0, 0);
    drain("R3 5-bit even ok");
    frame(8'h55, 7, 2, 1, 0);
    drain("R4 7-bit odd bad parity");
    frame(8'h2A, 6, 1, 1, 0);
    drain("R4 6-bit even bad parity");
    frame(8'h6B, 7, 2, 0, 0);
    drain("R4 7-bit odd ok");
    frame(8'h9E, 8, 3, 0, 0);
    drain("R4 mode3 no parity");

    // R6 framing error, line back high before the recheck (R7 no restart)
    frame(8'h3C, 8, 0, 0, 48);
    drain("R6 R7 framing error then idle");

    // R9 break begins mid-character; R7 restart from the low level
    char_len_i = 2'd3; par_mode_i = 2'd0;
    hold(1'b0, BT);
    for (int i = 0; i < 4; i++) hold(1'b1, BT);
    hold(1'b0, 24 * BT);
    hold(1'b1, 3 * BT);
    expect_char(8'h0F, 0, 1, 0);
    expect_char(8'h00, 0, 0, 1);
    drain("R9 R7 mid-character break");

    // R8 clean break, short high then low inside the guard, then a real frame
    hold(1'b0, 24 * BT);
    hold(1'b1, 4);
    hold(1'b0, BT);
    hold(1'b1, 2 * BT);
    expect_char(8'h00, 0, 0, 1);
    frame(8'hA5, 8, 0, 0, 0);
    drain("R8 break and idle guard");

    // R10 overrun: four characters with no pop
    frame(8'h11, 8, 0, 0, 0);
    frame(8'h22, 8, 0, 0, 0);
    frame(8'h33, 8, 0, 0, 0);
    frame(8'h44, 8, 0, 0, 0);
    drain("R10 overrun");

    // R11 pops on empty have no effect
    pop_i = 1'b1;
    repeat (2) @(negedge clk);
    pop_i = 1'b0;
    @(negedge clk);
    chk(ready_o === 1'b0, "R11 pop on empty", ready_o, 0);
    frame(8'h5A, 8, 0, 0, 0);
    drain("R11 after empty pops");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule